// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the control-register front end of an audio codec. A simple single-cycle bus addresses a 64-byte window of sixteen 32-bit direct registers, with the word number taken from the upper four bits of the 6-bit byte address. One direct register acts as a pointer. Its low five bits choose one of thirty-two 8-bit indirect registers. A second direct register acts as a window through which that chosen indirect register is read and written.

Some registers follow special access rules. One indirect register is write-only. Two carry fixed identification codes and ignore writes. One keeps a fixed version code and lets software change only a single bit. One direct register always reads zero. A control bit in another direct register restores the whole block to its power-on contents, and the written control value is still stored after that reset. Sample data, DMA and interrupts are not handled here, and the interrupt pin stays low.

Top module: `codec_rf_top`

## Requirements
- R1: After reset every direct register reads 0x00000000, and every indirect register reads 0x00 except index 12, which reads 0x8A, and index 25, which reads 0xA0.
- R2: The word number is bus_addr[5:2]. Writes to word numbers 0 and 3 and to 5 through 15 store all 32 bits, and later reads return them unchanged.
- R3: bus_wdata[4:0] of word 0 selects the indirect register. Word 0 still stores all 32 bits. A read of word 1 returns the selected 8-bit register zero-extended to 32 bits. A write of word 1 stores bus_wdata[7:0] into the selected register.
- R4: A read of indirect index 3 through word 1 always returns 0.
- R5: Writes through word 1 to indirect index 11 or index 25 are discarded, so both keep their contents.
- R6: A write through word 1 to indirect index 12 stores (bus_wdata & 0x40) | 0x8A.
- R7: Word 2 always reads 0, and writes to it have no effect.
- R8: A write to word 4 with bus_wdata[0]=1 restores the R1 state in all other registers, including the pointer. Word 4 then reads bus_wdata & 0x7F.
- R9: A write to word 4 with bus_wdata[0]=0 stores bus_wdata & 0x7F and changes no other register.
- R10: When bus_vld=1 and bus_we=0 at a clock edge, bus_rdata shows the addressed value right after that edge. At all other edges bus_rdata holds its value.
- R11: irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, held low |

## Verification
The assertions check these rules on every cycle: the version fields in indirect registers 12 and 25, the constant zero in word 2, read data holding still when no read occurs, zero data on reads of index 3, and the masked value that the control word takes after a reset write. The bench scenarios cover the rest: that a reset write clears the other registers while the pointer and data port keep working, that discarded writes really leave their registers unchanged, and that the pointer's upper bits are ignored. A long run of mixed random accesses is compared against a bench model to confirm the rules still hold when they interact.

// File: rtl/codec_rf_pkg.sv
`timescale 1ns/1ps
package codec_rf_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;
  localparam int DIR_CNT = 16;
  localparam int IND_CNT = 32;
  localparam int IND_W   = 8;
  localparam int WIDX_W  = $clog2(DIR_CNT);
  localparam int IIDX_W  = $clog2(IND_CNT);

  // direct word roles
  localparam int DIR_PTR  = 0;
  localparam int DIR_PORT = 1;
  localparam int DIR_RO   = 2;
  localparam int DIR_CTL  = 4;

  // indirect index roles
  localparam int IND_WO    = 3;
  localparam int IND_FIX_A = 11;
  localparam int IND_VER   = 12;
  localparam int IND_FIX_B = 25;

  localparam logic [IND_W-1:0]  VER_CODEC = 8'h8A;
  localparam logic [IND_W-1:0]  VER_CHIP  = 8'hA0;
  localparam logic [IND_W-1:0]  VER_KEEP  = 8'h40;
  localparam logic [DATA_W-1:0] CTL_MASK  = 32'h0000_007F;

  function automatic logic [IND_W-1:0] ind_reset_val(input int i);
    if (i == IND_VER)   return VER_CODEC;
    if (i == IND_FIX_B) return VER_CHIP;
    return '0;
  endfunction

  function automatic logic ind_writable(input int i);
    return !(i == IND_FIX_A || i == IND_FIX_B);
  endfunction

  function automatic logic [IND_W-1:0] ind_merge(input int i, input logic [IND_W-1:0] wb);
    if (i == IND_VER) return (wb & VER_KEEP) | VER_CODEC;
    return wb;
  endfunction

  function automatic logic [DATA_W-1:0] ind_read_ext(input logic [IIDX_W-1:0] idx,
                                                     input logic [IND_W-1:0] v);
    if (idx == IIDX_W'(IND_WO)) return '0;
    return {{(DATA_W-IND_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/codec_rf_decode.sv
`timescale 1ns/1ps
module codec_rf_decode
  import codec_rf_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int N_DIR = DIR_CNT
) (
  input  logic                      bus_vld,
  input  logic                      bus_we,
  input  logic [A_W-1:0]            bus_addr,
  input  logic                      wdata_lsb,
  output logic [A_W-3:0]            word_idx,
  output logic [N_DIR-1:0]          dir_wr,
  output logic                      port_wr,
  output logic                      rd_evt,
  output logic                      sw_reset
);
  localparam int W_W = A_W - 2;
  logic wr_evt;

  assign word_idx = bus_addr[A_W-1:2];
  assign wr_evt   = bus_vld && bus_we;
  assign rd_evt   = bus_vld && !bus_we;
  assign port_wr  = wr_evt && (word_idx == W_W'(DIR_PORT));

  for (genvar i = 0; i < N_DIR; i++) begin : g_sel
    if (i == DIR_PORT || i == DIR_RO) begin : g_none
      assign dir_wr[i] = 1'b0;
    end else begin : g_wr
      assign dir_wr[i] = wr_evt && (word_idx == W_W'(i));
    end
  end

  assign sw_reset = dir_wr[DIR_CTL] && wdata_lsb;
endmodule

// File: rtl/codec_rf_direct.sv
`timescale 1ns/1ps
module codec_rf_direct
  import codec_rf_pkg::*;
#(
  parameter int D_W = DATA_W,
  parameter int N_DIR = DIR_CNT
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sw_reset,
  input  logic [N_DIR-1:0]            dir_wr,
  input  logic [D_W-1:0]              wdata,
  output logic [N_DIR-1:0][D_W-1:0]   regs
);
  for (genvar i = 0; i < N_DIR; i++) begin : g_reg
    if (i == DIR_PORT || i == DIR_RO) begin : g_const
      assign regs[i] = '0;
    end else if (i == DIR_CTL) begin : g_ctl
      logic [D_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (dir_wr[i])  q <= wdata & D_W'(CTL_MASK);
      end
      assign regs[i] = q;
    end else begin : g_plain
      logic [D_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (sw_reset)   q <= '0;
        else if (dir_wr[i])  q <= wdata;
      end
      assign regs[i] = q;
    end
  end
endmodule

// File: rtl/codec_rf_indirect.sv
`timescale 1ns/1ps
module codec_rf_indirect
  import codec_rf_pkg::*;
#(
  parameter int B_W = IND_W,
  parameter int N_IND = IND_CNT,
  localparam int I_W = $clog2(N_IND)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_reset,
  input  logic            wr_en,
  input  logic [I_W-1:0]  idx,
  input  logic [B_W-1:0]  wbyte,
  output logic [B_W-1:0]  rd_byte,
  output logic [B_W-1:0]  ver_codec_q,
  output logic [B_W-1:0]  ver_chip_q
);
  logic [N_IND-1:0][B_W-1:0] bank;

  for (genvar i = 0; i < N_IND; i++) begin : g_ind
    localparam logic [B_W-1:0] RV = B_W'(ind_reset_val(i));
    logic [B_W-1:0] q;
    if (!ind_writable(i)) begin : g_fixed
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= RV;
        else if (sw_reset) q <= RV;
      end
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            q <= RV;
        else if (sw_reset)                     q <= RV;
        else if (wr_en && idx == I_W'(i))      q <= B_W'(ind_merge(i, wbyte));
      end
    end
    assign bank[i] = q;
  end

  assign rd_byte     = bank[idx];
  assign ver_codec_q = bank[IND_VER];
  assign ver_chip_q  = bank[IND_FIX_B];
endmodule

// File: rtl/codec_rf_top.sv
`timescale 1ns/1ps
module codec_rf_top
  import codec_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_we,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic [WIDX_W-1:0]             word_idx;
  logic [DIR_CNT-1:0]            dir_wr;
  logic                          port_wr;
  logic                          rd_evt;
  logic                          sw_reset_evt;
  logic [DIR_CNT-1:0][DATA_W-1:0] dir_regs;
  logic [IIDX_W-1:0]             cur_idx;
  logic [IND_W-1:0]              ind_rd_byte;
  logic [IND_W-1:0]              ver_codec_q;
  logic [IND_W-1:0]              ver_chip_q;
  logic [DATA_W-1:0]             dir_ro_q;
  logic [DATA_W-1:0]             dir_ctl_q;
  logic [DATA_W-1:0]             rd_next;
  logic [DATA_W-1:0]             rdata_q;

  codec_rf_decode #(.A_W(ADDR_W), .N_DIR(DIR_CNT)) u_dec (
    .bus_vld   (bus_vld),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wdata_lsb (bus_wdata[0]),
    .word_idx  (word_idx),
    .dir_wr    (dir_wr),
    .port_wr   (port_wr),
    .rd_evt    (rd_evt),
    .sw_reset  (sw_reset_evt)
  );

  codec_rf_direct #(.D_W(DATA_W), .N_DIR(DIR_CNT)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_reset (sw_reset_evt),
    .dir_wr   (dir_wr),
    .wdata    (bus_wdata),
    .regs     (dir_regs)
  );

  assign cur_idx   = dir_regs[DIR_PTR][IIDX_W-1:0];
  assign dir_ro_q  = dir_regs[DIR_RO];
  assign dir_ctl_q = dir_regs[DIR_CTL];

  codec_rf_indirect #(.B_W(IND_W), .N_IND(IND_CNT)) u_ind (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_reset    (sw_reset_evt),
    .wr_en       (port_wr),
    .idx         (cur_idx),
    .wbyte       (bus_wdata[IND_W-1:0]),
    .rd_byte     (ind_rd_byte),
    .ver_codec_q (ver_codec_q),
    .ver_chip_q  (ver_chip_q)
  );

  always_comb begin
    if (word_idx == WIDX_W'(DIR_PORT)) rd_next = ind_read_ext(cur_idx, ind_rd_byte);
    else                               rd_next = dir_regs[word_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_evt) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign irq       = 1'b0;
endmodule

// File: rtl/codec_rf_chk.sv
`timescale 1ns/1ps
module codec_rf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_vld,
  input logic        bus_we,
  input logic [5:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        sw_reset_evt,
  input logic [4:0]  cur_idx,
  input logic [7:0]  ver_codec_q,
  input logic [7:0]  ver_chip_q,
  input logic [31:0] dir_ro_q,
  input logic [31:0] dir_ctl_q
);
  // R6
  ver_codec_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ver_codec_q & 8'hBF) == 8'h8A);

  // R5
  ver_chip_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ver_chip_q == 8'hA0);

  // R7
  ro_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_ro_q == 32'h0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && !bus_we) |=> $stable(bus_rdata));

  // R4
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_we && bus_addr[5:2] == 4'd1 && cur_idx == 5'd3) |=> bus_rdata == 32'h0);

  // R8
  ctl_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_evt |=> (dir_ctl_q == ($past(bus_wdata) & 32'h7F)) && cur_idx == 5'd0);
endmodule

bind codec_rf_top codec_rf_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_vld      (bus_vld),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .sw_reset_evt (sw_reset_evt),
  .cur_idx      (cur_idx),
  .ver_codec_q  (ver_codec_q),
  .ver_chip_q   (ver_chip_q),
  .dir_ro_q     (dir_ro_q),
  .dir_ctl_q    (dir_ctl_q)
);

// File: tb/tb_codec_rf_top.sv
`timescale 1ns/1ps
module tb_codec_rf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] m_dir [16];
  logic [7:0]  m_ind [32];

  always #2.5 clk = ~clk;

  codec_rf_top dut (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic model_clear();
    for (int i = 0; i < 16; i++) m_dir[i] = 32'h0;
    for (int i = 0; i < 32; i++) m_ind[i] = 8'h0;
    m_ind[12] = 8'h8A;
    m_ind[25] = 8'hA0;
  endtask

  task automatic model_write(input int w, input logic [31:0] d);
    int p;
    p = int'(m_dir[0] % 32);
    case (w)
      1: begin
        if (p == 12)                m_ind[p] = 8'h8A | (d[7:0] & 8'h40);
        else if (p != 11 && p != 25) m_ind[p] = d[7:0];
      end
      2: ;
      4: begin
        if (d[0]) model_clear();
        m_dir[4] = d & 32'h7F;
      end
      default: m_dir[w] = d;
    endcase
  endtask

  function automatic logic [31:0] model_read(input int w);
    int p;
    p = int'(m_dir[0] % 32);
    if (w == 1) return (p == 3) ? 32'h0 : {24'h0, m_ind[p]};
    return m_dir[w];
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input int w, input logic [31:0] d);
    @(negedge clk);
    bus_vld = 1'b1; bus_we = 1'b1; bus_addr = 6'(w * 4); bus_wdata = d;
    @(posedge clk);
    model_write(w, d);
    #1 bus_vld = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_read(input int w, input string tag);
    logic [31:0] exp;
    exp = model_read(w);
    @(negedge clk);
    bus_vld = 1'b1; bus_we = 1'b0; bus_addr = 6'(w * 4); bus_wdata = $urandom;
    @(posedge clk);
    #1 bus_vld = 1'b0;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic ind_write(input int p, input logic [31:0] d);
    do_write(0, 32'(p));
    do_write(1, d);
  endtask

  task automatic ind_read(input int p, input string tag);
    do_write(0, 32'(p));
    do_read(1, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd7351));
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset contents
    for (int w = 0; w < 16; w++) do_read(w, "R1");
    ind_read(12, "R1");
    ind_read(25, "R1");
    ind_read(7, "R1");
    check("R11", {31'h0, irq}, 32'h0);

    // R2 full-width direct storage
    do_write(5, 32'hA5A5_3C3C); do_read(5, "R2");
    do_write(15, 32'hFFFF_FFFF); do_read(15, "R2");
    do_write(3, 32'h1234_5678); do_read(3, "R2");

    // R3 pointer, port, zero-extension, upper pointer bits ignored
    do_write(0, 32'hFFFF_FFE7); do_read(0, "R3");
    do_write(1, 32'hDEAD_BE5A); do_read(1, "R3");
    ind_read(7, "R3");

    // R4 write-only index
    ind_write(3, 32'hFF); do_read(1, "R4");

    // R5 fixed indices
    ind_write(11, 32'h55); do_read(1, "R5");
    ind_write(25, 32'h00); do_read(1, "R5");

    // R6 version register
    ind_write(12, 32'hFF); do_read(1, "R6");
    ind_write(12, 32'h00); do_read(1, "R6");

    // R7 read-only word
    do_write(2, 32'hCAFE_F00D); do_read(2, "R7");

    // R9 control write without reset
    ind_write(9, 32'h33);
    do_write(4, 32'hFFFF_FFF0); do_read(4, "R9");
    do_read(5, "R9"); do_read(1, "R9");

    // R8 software reset
    ind_write(12, 32'h40);
    do_write(4, 32'h0000_00C1);
    do_read(4, "R8"); do_read(5, "R8"); do_read(0, "R8");
    do_read(1, "R8");
    ind_read(9, "R8"); ind_read(12, "R8");

    // R10 read data holds across idle and write cycles
    do_write(6, 32'h0BAD_CAFE); do_read(6, "R10");
    held = bus_rdata;
    do_write(6, 32'h1111_2222);
    repeat (3) @(negedge clk);
    check("R10", bus_rdata, held);
    do_read(6, "R10");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int w;
      logic [31:0] d;
      w = int'($urandom % 16);
      d = $urandom;
      if (w == 4 && ($urandom % 4) != 0) d[0] = 1'b0;
      if (w == 0 && ($urandom % 3) == 0) d = 32'({$urandom % 3, 2'b11} ^ 32'h8);
      if ($urandom % 2) do_write(w, d);
      else do_read(w, (w == 1) ? "R3" : (w == 2) ? "R7" : (w == 4) ? "R9" : "R2");
    end
    check("R11", {31'h0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule